// File: doc/BRIEF.md
# Serial-In Latched Parallel Driver

This block is the logic core of a display column driver. Serial pixel data enters a chain of shift stages, one stage per rising clock edge. A bank of holding registers keeps a snapshot of the chain, so the panel keeps showing the previous row while the next row is shifted in. An enable input gates every parallel output. The last chain stage is also brought out on its own pin, so several drivers can be chained into one long serial line.

Channel 1 is the stage that receives serial data. A build-time parameter sets how channels map onto the parallel output pins. The forward build puts channel k+1 on pin k. The reversed build puts channel CHANNELS-k on pin k. These two builds correspond to boards that route the columns in opposite directions.

The holding bank is a clocked model of a transparent latch. On every rising edge where the latch enable is high, it takes the chain contents that were present during that cycle. On edges where the latch enable is low, it keeps its value. The output enable acts combinationally: it blanks or shows the outputs at once, with no clock edge needed. A synchronous active-low reset clears both the chain and the holding bank.

Top module: `spd_column_driver`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge clears every shift stage and every holding register. Afterwards `ser_cascade` is 0 and `par_out` is all zeros.
- R2: On each rising edge (reset inactive), stage 0 (channel 1) takes `ser_in`, and every stage i>0 takes the old value of stage i-1.
- R3: `ser_cascade` shows the last stage. A bit presented on `ser_in` at one edge appears on `ser_cascade` after the CHANNELS-th edge counted from that one, and stays there until the next edge.
- R4: Shifting and the cascade output behave the same whatever the levels of `latch_en` and `out_en`.
- R5: At a rising edge with `latch_en` high, the holding bank loads the chain contents that were present just before that edge.
- R6: At a rising edge with `latch_en` low, the holding bank keeps its value, even while new data shifts through the chain.
- R7: While `out_en` is low, all `par_out` bits are 0. This takes effect without a clock edge.
- R8: While `out_en` is high, each `par_out` bit equals the held bit of the channel mapped to it.
- R9: With `REVERSE_ORDER` = 0, `par_out[k]` carries channel k+1 (holding register k). With `REVERSE_ORDER` = 1, `par_out[k]` carries channel CHANNELS-k (holding register CHANNELS-1-k).
- R10: Reset is synchronous. Pulling `rst_n` low changes no output until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit for channel 1 |
| latch_en | input | 1 | High: the holding bank loads the chain at the edge |
| out_en | input | 1 | High: show held data; low: force outputs low |
| par_out | output | CHANNELS | Parallel channel outputs after mapping and gating |
| ser_cascade | output | 1 | Last chain stage, for the next driver in a chain |

## Verification
The hardest case to reach from the ports is a holding bank that keeps old data while the chain underneath it has already been overwritten. A fault there shows up only if the output is compared with a snapshot taken many edges earlier. The bench therefore records every bit it has shifted since reset. From that record it works out the chain contents at any past edge, and it keeps the snapshot from the last latching edge. Patterns are shifted with the latch enable held low, held high, and pulsed once. The output enable is also dropped during some shifts. Two instances, one of each channel ordering, receive the same stimulus.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic {
        ORDER_FWD = 1'b0,
        ORDER_REV = 1'b1
    } spd_order_e;

endpackage

// File: rtl/spd_shift_chain.sv
module spd_shift_chain #(
    parameter int STAGES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    output logic [STAGES-1:0] stage_q,
    output logic              tail_o
);

    localparam int LAST = STAGES - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[LAST-1:0], ser_in};
        end
    end

    assign tail_o = stage_q[LAST];

endmodule

// File: rtl/spd_latch_bank.sv
module spd_latch_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] snap_d,
    output logic [WIDTH-1:0] hold_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (load) begin
            hold_q <= snap_d;
        end
    end

endmodule

// File: rtl/spd_out_map.sv
module spd_out_map
    import spd_pkg::*;
#(
    parameter int WIDTH         = 32,
    parameter bit REVERSE_ORDER = 1'b0
) (
    input  logic [WIDTH-1:0] hold_q,
    input  logic             out_en,
    output logic [WIDTH-1:0] pins
);

    localparam spd_order_e ORDER = REVERSE_ORDER ? ORDER_REV : ORDER_FWD;

    generate
        for (genvar k = 0; k < WIDTH; k++) begin : g_pin
            if (ORDER == ORDER_REV) begin : g_rev
                assign pins[k] = out_en & hold_q[WIDTH-1-k];
            end else begin : g_fwd
                assign pins[k] = out_en & hold_q[k];
            end
        end
    endgenerate

endmodule

// File: rtl/spd_column_driver.sv
module spd_column_driver #(
    parameter int CHANNELS      = 32,
    parameter bit REVERSE_ORDER = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_in,
    input  logic                latch_en,
    input  logic                out_en,
    output logic [CHANNELS-1:0] par_out,
    output logic                ser_cascade
);

    logic [CHANNELS-1:0] sr_q;
    logic [CHANNELS-1:0] lat_q;

    spd_shift_chain #(
        .STAGES (CHANNELS)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .stage_q (sr_q),
        .tail_o  (ser_cascade)
    );

    spd_latch_bank #(
        .WIDTH (CHANNELS)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (latch_en),
        .snap_d (sr_q),
        .hold_q (lat_q)
    );

    spd_out_map #(
        .WIDTH         (CHANNELS),
        .REVERSE_ORDER (REVERSE_ORDER)
    ) u_map (
        .hold_q (lat_q),
        .out_en (out_en),
        .pins   (par_out)
    );

endmodule

// File: rtl/spd_column_driver_chk.sv
module spd_column_driver_chk #(
    parameter int CHANNELS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ser_in,
    input logic                latch_en,
    input logic                out_en,
    input logic [CHANNELS-1:0] par_out,
    input logic                ser_cascade,
    input logic [CHANNELS-1:0] sr_q,
    input logic [CHANNELS-1:0] lat_q
);

    localparam int LAST = CHANNELS - 1;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sr_q == '0 && lat_q == '0 && ser_cascade == 1'b0));

    assert_shift_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sr_q[0] == $past(ser_in));

    assert_shift_body_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sr_q[LAST:1] == $past(sr_q[LAST-1:0]));

    assert_cascade_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ser_cascade == $past(sr_q[LAST-1]));

    assert_latch_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> lat_q == $past(sr_q));

    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> $stable(lat_q));

    assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> par_out == '0);

    assert_show_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> $countones(par_out) == $countones(lat_q));

endmodule

bind spd_column_driver spd_column_driver_chk #(
    .CHANNELS (CHANNELS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .latch_en    (latch_en),
    .out_en      (out_en),
    .par_out     (par_out),
    .ser_cascade (ser_cascade),
    .sr_q        (sr_q),
    .lat_q       (lat_q)
);

// File: tb/spd_column_driver_bench.sv
`timescale 1ns/1ps
module spd_column_driver_bench;

    localparam int N = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst_n;
    logic         ser_in;
    logic         latch_en;
    logic         out_en;
    logic [N-1:0] out_f;
    logic [N-1:0] out_r;
    logic         casc_f;
    logic         casc_r;

    int n_cmp = 0;
    int n_bad = 0;

    bit           sent[$];
    logic [N-1:0] held;

    spd_column_driver #(.CHANNELS(N), .REVERSE_ORDER(1'b0)) u_spd_column_driver (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
        .out_en(out_en), .par_out(out_f), .ser_cascade(casc_f));

    spd_column_driver #(.CHANNELS(N), .REVERSE_ORDER(1'b1)) u_spd_column_driver_rev (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
        .out_en(out_en), .par_out(out_r), .ser_cascade(casc_r));

    function automatic logic [N-1:0] bitrev(input logic [N-1:0] v);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = v[N-1-i];
        return r;
    endfunction

    // chain contents after the first e recorded edges: stage s = bit sent at edge e-1-s
    function automatic logic [N-1:0] chain_at(input int e);
        logic [N-1:0] w;
        for (int s = 0; s < N; s++) w[s] = (e-1-s >= 0) ? sent[e-1-s] : 1'b0;
        return w;
    endfunction

    task automatic chk_vec(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        logic [N-1:0] w;
        w = out_en ? held : '0;
        chk_vec({req, " fwd"}, out_f, w);
        chk_vec({req, " rev"}, out_r, bitrev(w));
    endtask

    task automatic chk_cascade(input string req);
        logic e;
        e = (sent.size() >= N) ? sent[sent.size()-N] : 1'b0;
        chk_bit({req, " fwd"}, casc_f, e);
        chk_bit({req, " rev"}, casc_r, e);
    endtask

    // one rising edge; inputs were set after the previous edge
    task automatic edge_bit(input logic b);
        ser_in = b;
        if (latch_en) held = chain_at(sent.size());
        @(posedge clk);
        sent.push_back(b);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        sent.delete();
        held = '0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run_word(input logic [N-1:0] p, input int mode);
        latch_en = (mode == 1);
        out_en   = (mode != 2);
        for (int i = 0; i < N; i++) begin
            edge_bit(p[i]);
            chk_cascade("R3 R4 cascade");
            if (mode == 1) chk_outputs("R5 latch follows chain");
            else if (mode == 2) chk_outputs("R7 R4 blanked during shift");
            else chk_outputs("R6 latch holds while shifting");
        end
        out_en   = 1'b1;
        latch_en = 1'b1;
        edge_bit(1'b0);
        latch_en = 1'b0;
        chk_outputs("R8 R9 latched word shown");
        // channel layout: the last bit shifted sits in channel 1
        chk_bit("R2 channel1 fwd", out_f[0], p[N-1]);
        chk_bit("R9 channel1 rev", out_r[N-1], p[N-1]);
        out_en = 1'b0;
        #1;
        chk_vec("R7 blank fwd", out_f, '0);
        chk_vec("R7 blank rev", out_r, '0);
        out_en = 1'b1;
        #1;
        chk_outputs("R8 reshown");
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [N-1:0] pats [8];
        rst_n    = 1'b0;
        ser_in   = 1'b0;
        latch_en = 1'b1;
        out_en   = 1'b1;
        held     = '0;
        do_reset();
        chk_vec("R1 reset fwd", out_f, '0);
        chk_vec("R1 reset rev", out_r, '0);
        chk_bit("R1 reset cascade", casc_f, 1'b0);

        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h8000_0001;
        pats[4] = 32'h1234_5678; pats[5] = 32'hDEAD_BEEF;
        pats[6] = 32'h0F0F_00FF; pats[7] = 32'h7FFF_FFFE;
        for (int i = 0; i < 8; i++) run_word(pats[i], i % 3);
        for (int k = 0; k < N; k++) run_word(32'h1 << k, k % 3);
        for (int k = 0; k < N; k++) run_word(~(32'h1 << k), (k + 1) % 3);

        // R10: reset asserted between edges changes nothing until the edge
        out_en = 1'b1;
        rst_n  = 1'b0;
        #1;
        chk_outputs("R10 no change before edge");
        chk_cascade("R10 cascade before edge");
        @(posedge clk);
        #1;
        chk_vec("R10 R1 cleared fwd", out_f, '0);
        chk_vec("R10 R1 cleared rev", out_r, '0);
        chk_bit("R10 R1 cleared cascade", casc_r, 1'b0);
        rst_n = 1'b1;
        sent.delete();
        held = '0;
        run_word(32'hC3C3_3C3C, 0);
        finish_run();
    end

endmodule